// File: doc/BRIEF.md
# I2C Master Register and FIFO Front-End

This block is the software-facing half of an I2C master. A host reaches it through a simple 32-bit register port with word addresses. It holds a transmit queue and a receive queue, 16 entries each. It also holds a control word, a status word, a programmable receive threshold, an interrupt status word with an enable mask and a global gate, and a reset register that needs a key.

The bit-level bus engine sits on the other side. The engine pops transmit entries, each a byte plus start and stop flags in bits 8 and 9. It pushes received bytes, reports whether the bus is busy, and pulses on lost arbitration or on a transmit error. The block turns these engine events, and the fill levels of its own queues, into sticky interrupt bits and a single interrupt line.

Register word addresses:

| Address | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | transmit data |
| 3 | receive data |
| 4 | transmit occupancy |
| 5 | receive occupancy |
| 6 | receive threshold |
| 7 | global interrupt enable |
| 8 | interrupt status |
| 9 | interrupt enable |
| 10 | reset |

Read data is registered. It is valid in the cycle after the read strobe.

Top module: `i2c_regfront`

## Requirements
- R1: After reset, these registers read as follows: status (addr 1) 0xC0, control (addr 0) 0, receive threshold (addr 6) 0xF, interrupt status (addr 8) 0, interrupt enable (addr 9) 0, global interrupt enable (addr 7) 0. The `irq` output is low.
- R2: Each write to addr 2 queues one transmit entry, and `eng_tx_data` presents the entries in write order. A write while 16 entries are stored is dropped. Status bit 4 is set exactly when the transmit queue is full.
- R3: Occupancy registers return the number of stored entries minus one, and 0 when the queue is empty. Addr 4 covers the transmit queue and addr 5 the receive queue.
- R4: Reading addr 3 pops the oldest received byte. A read while the receive queue is empty returns the most recently popped byte and leaves the queue empty. Status bit 6 marks the receive queue empty.
- R5: Interrupt status bit 3 is set when the receive queue reaches threshold+1 entries. The threshold is the zero-based value in addr 6.
- R6: Writing interrupt status (addr 8) toggles every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: `irq` is high exactly when the global enable (addr 7, bit 0) is 1 and some interrupt status bit is set whose enable bit (addr 9) is also set. Writing 0 to addr 7 forces `irq` low.
- R8: Writing 0xA to addr 10 returns every register and both queues to their reset state. Any other value written there changes nothing.
- R9: Control bit 0 drives `eng_enable`. While control bit 1 is set, the transmit queue is held empty and writes to addr 2 are dropped.
- R10: Status bit 2 follows `eng_bus_busy`. Status bit 5 is set when the receive queue holds 16 entries. Status bit 7 marks the transmit queue empty.
- R11: The following events set interrupt status bits:
  - bit 0 on an `eng_arb_lost` pulse;
  - bit 1 on an `eng_tx_err` pulse;
  - bit 2 when the transmit queue becomes empty;
  - bit 4 when `eng_bus_busy` falls;
  - bit 7 when the transmit queue drops to 8 or fewer entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| eng_enable | output | 1 | Device enable toward the engine |
| eng_tx_empty | output | 1 | Transmit queue empty |
| eng_tx_data | output | 10 | Oldest transmit entry: byte, start flag (bit 8), stop flag (bit 9) |
| eng_tx_pop | input | 1 | Engine consumes the oldest transmit entry |
| eng_rx_full | output | 1 | Receive queue full |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_bus_busy | input | 1 | Bus busy level from the engine |
| eng_arb_lost | input | 1 | Arbitration lost pulse |
| eng_tx_err | input | 1 | Transmit error pulse |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted queue pointer or count shows up at the occupancy registers and the status empty and full bits. It also shows up as out-of-order bytes at `eng_tx_data` or in receive reads, one read after the faulty push or pop. A wrong edge-detector state shows up as a missing or spurious interrupt status bit, readable two cycles after the event. That bit also drives `irq` in the cycle after it is set. A soft-reset decode that is too loose or too strict is exposed by reading control and threshold in the cycle after the reset register is written.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    typedef enum logic [3:0] {
        A_CTRL = 4'd0,
        A_STAT = 4'd1,
        A_TXD  = 4'd2,
        A_RXD  = 4'd3,
        A_TXO  = 4'd4,
        A_RXO  = 4'd5,
        A_THR  = 4'd6,
        A_GIE  = 4'd7,
        A_ISR  = 4'd8,
        A_IER  = 4'd9,
        A_RST  = 4'd10
    } reg_addr_e;

    localparam logic [3:0] RST_KEY = 4'hA;

    // interrupt status bit positions
    localparam int IB_ARB   = 0;
    localparam int IB_TXERR = 1;
    localparam int IB_TXE   = 2;
    localparam int IB_RXTH  = 3;
    localparam int IB_BNB   = 4;
    localparam int IB_HALF  = 7;

    typedef struct packed {
        logic flush;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic tx_empty;
        logic rx_empty;
        logic rx_full;
        logic tx_full;
        logic rsv3;
        logic busy;
        logic [1:0] rsv0;
    } stat_t;

    function automatic logic [7:0] edge_rise(input logic now, input logic prev, input int pos);
        logic [7:0] v;
        v = '0;
        v[pos] = now & ~prev;
        return v;
    endfunction

endpackage

// File: rtl/i2c_rf_fifo.sv
module i2c_rf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = cnt;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (clr)
        cnt <= CW'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (clr)
        (push && full && !pop) |=> $stable(cnt));

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (clr)
        (pop && empty && !push) |=> (cnt == '0));

endmodule

// File: rtl/i2c_rf_irq.sv
module i2c_rf_irq (
    input  logic       clk,
    input  logic       clr,
    input  logic [7:0] set_vec,
    input  logic       tgl_we,
    input  logic [7:0] tgl_data,
    input  logic [7:0] ier,
    input  logic       gie,
    output logic [7:0] isr,
    output logic       irq
);
    logic [7:0] isr_q;

    always_ff @(posedge clk) begin
        if (clr) isr_q <= '0;
        else     isr_q <= (tgl_we ? (isr_q ^ tgl_data) : isr_q) | set_vec;
    end

    assign isr = isr_q;
    assign irq = gie && |(isr_q & ier);

    // R6
    toggle_chk: assert property (@(posedge clk) disable iff (clr)
        (tgl_we && set_vec == 8'h00) |=> (isr_q == $past(isr_q ^ tgl_data)));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (clr)
        irq |-> gie);

endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
    import i2c_rf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TXW   = 10,
    parameter int RXW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [3:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            eng_enable,
    output logic            eng_tx_empty,
    output logic [TXW-1:0]  eng_tx_data,
    input  logic            eng_tx_pop,
    output logic            eng_rx_full,
    input  logic            eng_rx_push,
    input  logic [RXW-1:0]  eng_rx_data,
    input  logic            eng_bus_busy,
    input  logic            eng_arb_lost,
    input  logic            eng_tx_err,
    output logic            irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    reg_addr_e addr;
    assign addr = reg_addr_e'(reg_addr);

    logic soft_rst, clr;
    assign soft_rst = reg_wr && (addr == A_RST) && (reg_wdata == 32'(RST_KEY));
    assign clr      = rst || soft_rst;

    ctrl_t           ctrl_q;
    logic [AW-1:0]   thr_q;
    logic            gie_q;
    logic [7:0]      ier_q;
    logic [RXW-1:0]  rx_last;
    logic [31:0]     rdata_q;

    logic [TXW-1:0]  tx_dout;
    logic [RXW-1:0]  rx_dout;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            tx_push, rx_pop;

    assign tx_push = reg_wr && (addr == A_TXD) && !ctrl_q.flush;
    assign rx_pop  = reg_rd && (addr == A_RXD);

    i2c_rf_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .clr(clr || ctrl_q.flush),
        .push(tx_push), .din(reg_wdata[TXW-1:0]),
        .pop(eng_tx_pop), .dout(tx_dout),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    i2c_rf_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .clr(clr),
        .push(eng_rx_push), .din(eng_rx_data),
        .pop(rx_pop), .dout(rx_dout),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    // interrupt event sources, edge-detected against their previous level
    logic rx_hit, tx_half;
    logic prev_txe, prev_hit, prev_busy, prev_half;
    logic [7:0] set_vec, isr;

    assign rx_hit  = rx_cnt > CW'(thr_q);
    assign tx_half = tx_cnt <= CW'(DEPTH / 2);

    always_ff @(posedge clk) begin
        if (clr) begin
            prev_txe  <= 1'b1;
            prev_hit  <= 1'b0;
            prev_busy <= 1'b0;
            prev_half <= 1'b1;
        end else begin
            prev_txe  <= tx_empty;
            prev_hit  <= rx_hit;
            prev_busy <= eng_bus_busy;
            prev_half <= tx_half;
        end
    end

    always_comb begin
        set_vec = '0;
        set_vec[IB_ARB]   = eng_arb_lost;
        set_vec[IB_TXERR] = eng_tx_err;
        set_vec = set_vec
                | edge_rise(tx_empty, prev_txe, IB_TXE)
                | edge_rise(rx_hit, prev_hit, IB_RXTH)
                | edge_rise(!eng_bus_busy, !prev_busy, IB_BNB)
                | edge_rise(tx_half, prev_half, IB_HALF);
    end

    i2c_rf_irq u_irq (
        .clk(clk), .clr(clr), .set_vec(set_vec),
        .tgl_we(reg_wr && (addr == A_ISR)), .tgl_data(reg_wdata[7:0]),
        .ier(ier_q), .gie(gie_q), .isr(isr), .irq(irq)
    );

    // host-writable configuration
    always_ff @(posedge clk) begin
        if (clr) begin
            ctrl_q <= '0;
            thr_q  <= AW'(DEPTH - 1);
            gie_q  <= 1'b0;
            ier_q  <= '0;
        end else if (reg_wr) begin
            case (addr)
                A_CTRL: ctrl_q <= ctrl_t'(reg_wdata[1:0]);
                A_THR:  thr_q  <= reg_wdata[AW-1:0];
                A_GIE:  gie_q  <= reg_wdata[0];
                A_IER:  ier_q  <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    stat_t stat;
    always_comb begin
        stat          = '0;
        stat.tx_empty = tx_empty;
        stat.rx_empty = rx_empty;
        stat.rx_full  = rx_full;
        stat.tx_full  = tx_full;
        stat.busy     = eng_bus_busy;
    end

    logic [CW-1:0] tx_occ, rx_occ;
    assign tx_occ = tx_empty ? '0 : tx_cnt - 1'b1;
    assign rx_occ = rx_empty ? '0 : rx_cnt - 1'b1;

    logic [31:0] rd_mux;
    always_comb begin
        case (addr)
            A_CTRL:  rd_mux = 32'(ctrl_q);
            A_STAT:  rd_mux = 32'(stat);
            A_RXD:   rd_mux = 32'(rx_empty ? rx_last : rx_dout);
            A_TXO:   rd_mux = 32'(tx_occ);
            A_RXO:   rd_mux = 32'(rx_occ);
            A_THR:   rd_mux = 32'(thr_q);
            A_GIE:   rd_mux = 32'(gie_q);
            A_ISR:   rd_mux = 32'(isr);
            A_IER:   rd_mux = 32'(ier_q);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            rx_last <= '0;
            rdata_q <= '0;
        end else begin
            if (rx_pop && !rx_empty) rx_last <= rx_dout;
            if (reg_rd) rdata_q <= rd_mux;
        end
    end

    assign reg_rdata    = rdata_q;
    assign eng_enable   = ctrl_q.en;
    assign eng_tx_empty = tx_empty;
    assign eng_tx_data  = tx_dout;
    assign eng_rx_full  = rx_full;

    // R8
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctrl_q == '0 && thr_q == AW'(DEPTH - 1) && isr == '0));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flush && !soft_rst) |=> tx_empty);

    // R10
    busy_stat_chk: assert property (@(posedge clk) disable iff (rst)
        stat.busy == eng_bus_busy);

endmodule

// File: tb/sim_i2c_regfront.sv
module sim_i2c_regfront;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_enable, eng_tx_empty, eng_rx_full, irq;
    logic [9:0]  eng_tx_data;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_bus_busy = 1'b0, eng_arb_lost = 1'b0, eng_tx_err = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] v;

    always #2 clk = ~clk;   // 250 MHz

    i2c_regfront u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_enable(eng_enable), .eng_tx_empty(eng_tx_empty),
        .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
        .eng_rx_full(eng_rx_full), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_bus_busy(eng_bus_busy),
        .eng_arb_lost(eng_arb_lost), .eng_tx_err(eng_tx_err), .irq(irq)
    );

    // {write, addr, wdata, expected read}
    localparam int NV = 12;
    localparam logic [68:0] VEC [NV] = '{
        {1'b1, 4'd0, 32'h1,  32'h0},
        {1'b0, 4'd0, 32'h0,  32'h1},
        {1'b1, 4'd6, 32'h3,  32'h0},
        {1'b0, 4'd6, 32'h0,  32'h3},
        {1'b1, 4'd9, 32'hFF, 32'h0},
        {1'b0, 4'd9, 32'h0,  32'hFF},
        {1'b1, 4'd7, 32'h1,  32'h0},
        {1'b0, 4'd7, 32'h0,  32'h1},
        {1'b0, 4'd4, 32'h0,  32'h0},
        {1'b0, 4'd5, 32'h0,  32'h0},
        {1'b0, 4'd1, 32'h0,  32'hC0},
        {1'b0, 4'd8, 32'h0,  32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic tx_pop();
        @(negedge clk); eng_tx_pop = 1'b1;
        @(negedge clk); eng_tx_pop = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk); eng_rx_push = 1'b0;
    endtask

    task automatic clear_isr();
        logic [31:0] s;
        rd(4'd8, s);
        wr(4'd8, s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(4'd1, v); check("R1 status", v, 32'hC0);
        rd(4'd0, v); check("R1 control", v, 32'h0);
        rd(4'd6, v); check("R1 threshold", v, 32'hF);
        rd(4'd8, v); check("R1 isr", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // table walk: configuration registers
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][67:64], v);
                check("R3 R1 vector", v, VEC[i][31:0]);
            end
        end
        check("R9 enable pin", {31'b0, eng_enable}, 32'h1);

        // R2 transmit fill and overflow drop
        for (int i = 0; i < 17; i++) wr(4'd2, 32'h100 + i);
        rd(4'd4, v); check("R2 R3 tx occupancy", v, 32'd15);
        rd(4'd1, v); check("R2 tx full bit4", v & 32'h90, 32'h10);
        check("R2 head entry", {22'b0, eng_tx_data}, 32'h100);
        for (int i = 0; i < 8; i++) tx_pop();
        check("R2 order", {22'b0, eng_tx_data}, 32'h108);
        rd(4'd8, v); check("R11 half-empty bit7", v & 32'h84, 32'h80);
        for (int i = 0; i < 8; i++) tx_pop();
        repeat (2) @(negedge clk);
        rd(4'd8, v); check("R11 tx-empty bit2", v & 32'h84, 32'h84);
        check("R7 irq on", {31'b0, irq}, 32'h1);
        wr(4'd7, 32'h0);
        check("R7 irq gated", {31'b0, irq}, 32'h0);
        wr(4'd7, 32'h1);

        // R6 toggle semantics
        wr(4'd8, 32'h84);
        rd(4'd8, v); check("R6 toggle clear", v, 32'h0);
        wr(4'd8, 32'h01);
        rd(4'd8, v); check("R6 toggle set", v, 32'h01);
        wr(4'd8, 32'h00);
        rd(4'd8, v); check("R6 zero no effect", v, 32'h01);
        wr(4'd8, 32'h01);

        // R5 threshold (threshold = 3 -> fires on 4th byte)
        for (int i = 0; i < 3; i++) rx_push(8'hA0 + 8'(i));
        rd(4'd8, v); check("R5 below threshold", v & 32'h08, 32'h0);
        rx_push(8'hA3);
        @(negedge clk);
        rd(4'd8, v); check("R5 at threshold", v & 32'h08, 32'h08);
        rd(4'd5, v); check("R3 rx occupancy", v, 32'd3);
        for (int i = 0; i < 4; i++) begin
            rd(4'd3, v); check("R4 rx order", v, 32'hA0 + i);
        end
        rd(4'd3, v); check("R4 empty read repeats", v, 32'hA3);
        rd(4'd5, v); check("R4 no underflow", v, 32'd0);
        rd(4'd1, v); check("R4 rx empty bit6", v & 32'h40, 32'h40);

        // R10 receive full, overflow drop
        for (int i = 0; i < 17; i++) rx_push(8'(i));
        rd(4'd1, v); check("R10 rx full bit5", v & 32'h60, 32'h20);
        rd(4'd5, v); check("R10 rx drop", v, 32'd15);
        check("R10 rx full pin", {31'b0, eng_rx_full}, 32'h1);
        rd(4'd3, v); check("R10 first kept", v, 32'h0);

        // R10 / R11 bus busy and engine events
        clear_isr();
        @(negedge clk); eng_bus_busy = 1'b1;
        @(negedge clk);
        rd(4'd1, v); check("R10 busy bit2", v & 32'h04, 32'h04);
        eng_bus_busy = 1'b0;
        repeat (2) @(negedge clk);
        rd(4'd8, v); check("R11 bus-not-busy bit4", v & 32'h10, 32'h10);
        @(negedge clk); eng_arb_lost = 1'b1;
        @(negedge clk); eng_arb_lost = 1'b0; eng_tx_err = 1'b1;
        @(negedge clk); eng_tx_err = 1'b0;
        rd(4'd8, v); check("R11 arb and err bits", v & 32'h03, 32'h03);

        // R9 transmit flush
        for (int i = 0; i < 3; i++) wr(4'd2, 32'h55);
        wr(4'd0, 32'h3);
        wr(4'd2, 32'h77);
        rd(4'd1, v); check("R9 flush empties", v & 32'h80, 32'h80);
        rd(4'd4, v); check("R9 push blocked", v, 32'h0);
        wr(4'd0, 32'h1);
        rd(4'd1, v); check("R9 still empty", v & 32'h80, 32'h80);

        // R8 keyed soft reset
        wr(4'd10, 32'h5);
        rd(4'd0, v); check("R8 wrong key ignored", v, 32'h1);
        rd(4'd6, v); check("R8 wrong key thr", v, 32'h3);
        wr(4'd10, 32'hA);
        rd(4'd0, v); check("R8 control cleared", v, 32'h0);
        rd(4'd6, v); check("R8 threshold restored", v, 32'hF);
        rd(4'd8, v); check("R8 isr cleared", v, 32'h0);
        rd(4'd1, v); check("R8 queues empty", v, 32'hC0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule